// File: doc/BRIEF.md
# Cartridge RAM with Split Read/Write Windows

This block adds 128 bytes of byte-wide storage to a cartridge-style bus that carries only an address, a data bus and a cycle strobe. It has no read/write line. The block tells reads from writes by address alone. The low 256 bytes of the selected 4K space form two halves. One half is the read port and the other half is the write port. Both halves map onto the same 128 storage bytes, using address bits 6..0 as the byte index. Every other address in the selected space passes the external ROM byte through to the bus. The ROM bytes that sit under the 256-byte RAM area can never be seen while the RAM is on.

A write completes in the clock in which the strobe is first seen low after an access. The block stores the bus data present in that clock, so data that becomes valid late in the cycle is still captured. A parameter chooses which half is the read port. A registered enable input can switch the RAM off. When it is off, the whole 4K space behaves as plain ROM. Writes that software aims at ROM addresses, for example to burn time, leave the storage untouched.

Top module: `cart_split_ram`

## Requirements
- R1: After reset all 128 storage bytes read as 8'h00.
- R2: With the RAM on and the default ordering (READ_LOW=1), an access with A12=1, A11..A8=0 and A7=0 drives `bus_drive` high and returns the stored byte at index A6..A0 on `bus_rdata`, never the ROM byte.
- R3: With the RAM on and the default ordering, an access with A12=1, A11..A8=0 and A7=1 writes into index A6..A0. The value written is `bus_wdata` as sampled in the first clock in which `bus_strobe` is low after the access.
- R4: `bus_drive` is low during every write-window access and whenever `bus_strobe` is low.
- R5: With A12=0 the block never drives the bus and never changes storage.
- R6: With A12=1 and A11..A8 not all zero, the block drives `rom_rdata` onto `bus_rdata` and leaves storage unchanged, whatever the bus data is.
- R7: A strobe held high over several clocks causes exactly one write. That write uses the data present in the clock in which the strobe is first seen low.
- R8: With READ_LOW=0 the two halves swap roles: A7=1 is the read port and A7=0 is the write port.
- R9: `ram_on` is registered. Once it has been low at a clock edge, every access with A12=1 drives ROM data and no write occurs. Storage keeps its contents and is readable again once `ram_on` has been registered high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_addr | input | 13 | Cartridge address A12..A0 |
| bus_wdata | input | 8 | Data present on the bus from the processor side |
| rom_rdata | input | 8 | Byte from the external ROM at the current address |
| bus_strobe | input | 1 | High while a bus access is in progress |
| ram_on | input | 1 | RAM enable, sampled at each clock edge |
| bus_rdata | output | 8 | Byte to place on the bus |
| bus_drive | output | 1 | Output enable for `bus_rdata` |

## Verification
A wrong byte index or a half decoded the wrong way round corrupts storage silently. That fault shows at the ports only on the next read-window access to the affected index, which may come many cycles later. The bench therefore writes every index with a distinct value and reads every index back. A missed or doubled strobe edge shows in the clock right after the access as a stale or wrong byte. A badly registered enable shows within one access as a swap between ROM and RAM data.

// File: rtl/cram_pkg.sv
package cram_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE   = 2'd0,
        ACC_RAM_RD = 2'd1,
        ACC_RAM_WR = 2'd2,
        ACC_ROM    = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/cram_decode.sv
module cram_decode
    import cram_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int IDX_W    = 7,
    parameter bit READ_LOW = 1'b1
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              en_i,
    output acc_kind_e         kind_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam int HALF_BIT = IDX_W;
    localparam int SEL_BIT  = ADDR_W - 1;

    logic rd_half;
    logic in_region;

    // Parameter picks which half of the 256-byte area is the read port.
    generate
        if (READ_LOW) begin : g_rd_low
            assign rd_half = ~addr_i[HALF_BIT];
        end else begin : g_rd_high
            assign rd_half = addr_i[HALF_BIT];
        end
    endgenerate

    assign in_region = (addr_i[SEL_BIT-1:HALF_BIT+1] == '0);
    assign idx_o     = addr_i[IDX_W-1:0];

    always_comb begin
        kind_o = ACC_IDLE;
        if (addr_i[SEL_BIT]) begin
            if (!en_i || !in_region) begin
                kind_o = ACC_ROM;
            end else if (rd_half) begin
                kind_o = ACC_RAM_RD;
            end else begin
                kind_o = ACC_RAM_WR;
            end
        end
    end
endmodule

// File: rtl/cram_seq.sv
module cram_seq #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic              en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              fall_o,
    output logic              en_o,
    output logic [ADDR_W-1:0] lat_o
);
    typedef struct packed {
        logic              strb;
        logic              en;
        logic [ADDR_W-1:0] lat;
    } seq_t;

    seq_t cur_q;
    seq_t nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.strb = strobe_i;
        nxt_d.en   = en_i;
        if (strobe_i) begin
            nxt_d.lat = addr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign fall_o = cur_q.strb & ~strobe_i;
    assign en_o   = cur_q.en;
    assign lat_o  = cur_q.lat;
endmodule

// File: rtl/cram_store.sv
module cram_store #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [$clog2(DEPTH)-1:0] widx_i,
    input  logic [DATA_W-1:0]        wdata_i,
    input  logic [$clog2(DEPTH)-1:0] ridx_i,
    output logic [DATA_W-1:0]        rdata_o
);
    logic [DEPTH-1:0][DATA_W-1:0] mem_q;
    logic [DEPTH-1:0][DATA_W-1:0] mem_d;

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[widx_i] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = mem_q[ridx_i];

    // R3: the written byte lands at the addressed index
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mem_q[$past(widx_i)] == $past(wdata_i)));

    // R6: without a write strobe no byte changes
    assert_hold_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(mem_q));
endmodule

// File: rtl/cart_split_ram.sv
module cart_split_ram
    import cram_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 128,
    parameter bit READ_LOW = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic              bus_strobe,
    input  logic              ram_on,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_drive
);
    localparam int IDX_W = $clog2(DEPTH);

    logic              fall;
    logic              en_q;
    logic [ADDR_W-1:0] lat_addr;
    acc_kind_e         cur_kind;
    acc_kind_e         lat_kind;
    logic [IDX_W-1:0]  cur_idx;
    logic [IDX_W-1:0]  lat_idx;
    logic [DATA_W-1:0] ram_rdata;
    logic              wr_go;

    cram_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (bus_strobe),
        .en_i     (ram_on),
        .addr_i   (bus_addr),
        .fall_o   (fall),
        .en_o     (en_q),
        .lat_o    (lat_addr)
    );

    cram_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .READ_LOW(READ_LOW)) u_dec_cur (
        .addr_i (bus_addr),
        .en_i   (en_q),
        .kind_o (cur_kind),
        .idx_o  (cur_idx)
    );

    cram_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .READ_LOW(READ_LOW)) u_dec_lat (
        .addr_i (lat_addr),
        .en_i   (en_q),
        .kind_o (lat_kind),
        .idx_o  (lat_idx)
    );

    assign wr_go = fall && (lat_kind == ACC_RAM_WR);

    cram_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_go),
        .widx_i  (lat_idx),
        .wdata_i (bus_wdata),
        .ridx_i  (cur_idx),
        .rdata_o (ram_rdata)
    );

    always_comb begin
        bus_drive = bus_strobe && ((cur_kind == ACC_RAM_RD) || (cur_kind == ACC_ROM));
        bus_rdata = (cur_kind == ACC_RAM_RD) ? ram_rdata : rom_rdata;
    end

    // R5: the low half of the address space is never driven
    always_comb begin
        if (rst_n && !bus_addr[ADDR_W-1]) begin
            assert_no_drive_low_R5: assert (!bus_drive);
        end
    end

    // R7: a write only completes once the strobe has dropped
    assert_write_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> !bus_strobe);

    // R9: a write needs the enable seen high at the previous edge
    assert_write_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> $past(ram_on));

    // R4: the bus is never driven while the strobe is low
    assert_quiet_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_strobe |-> !bus_drive);
endmodule

// File: tb/sim_cart_split_ram.sv
module sim_cart_split_ram;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rom = '0;
    logic        strobe = 1'b0;
    logic        ram_on = 1'b1;
    logic [7:0]  dout0, dout1;
    logic        de0, de1;

    int checks = 0;
    int failures = 0;
    int ncyc = 0;
    logic en_m = 1'b1;
    logic [7:0] m0 [128];
    logic [7:0] m1 [128];

    always #(CLK_PERIOD/2) clk = ~clk;

    cart_split_ram #(.READ_LOW(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
        .rom_rdata(rom), .bus_strobe(strobe), .ram_on(ram_on),
        .bus_rdata(dout0), .bus_drive(de0)
    );

    cart_split_ram #(.READ_LOW(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
        .rom_rdata(rom), .bus_strobe(strobe), .ram_on(ram_on),
        .bus_rdata(dout1), .bus_drive(de1)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        ncyc++;
        if (ncyc > 150000) begin
            failures++;
            $display("FAIL watchdog (all requirements): act=%0d exp=<150000 cycles", ncyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int k);
        return 8'((i * 37 + k * 11 + 5) ^ (i << 3));
    endfunction

    // One complete access: strobe high for one clock, then low for one clock.
    task automatic cyc(input logic [12:0] a, input logic [7:0] d, input string tag);
        logic hit, rd0, wr0, rd1, wr1, exp_de0, exp_de1;
        logic [7:0] rexp, e0, e1;
        hit = a[12] && (a[11:8] == 4'h0) && en_m;
        rd0 = hit && !a[7];
        wr0 = hit && a[7];
        rd1 = hit && a[7];
        wr1 = hit && !a[7];
        rexp = a[7:0] ^ 8'h5A;
        exp_de0 = a[12] && !wr0;
        exp_de1 = a[12] && !wr1;
        e0 = rd0 ? m0[a[6:0]] : rexp;
        e1 = rd1 ? m1[a[6:0]] : rexp;
        @(negedge clk);
        addr = a; wdata = d; rom = rexp; strobe = 1'b1;
        #1;
        chk(de0 == exp_de0, tag, "u0 drive", int'(de0), int'(exp_de0));
        if (exp_de0) chk(dout0 == e0, tag, "u0 data", int'(dout0), int'(e0));
        chk(de1 == exp_de1, tag, "u1 drive", int'(de1), int'(exp_de1));
        if (exp_de1) chk(dout1 == e1, tag, "u1 data", int'(dout1), int'(e1));
        @(negedge clk);
        strobe = 1'b0;
        #1;
        chk(!de0 && !de1, "R4", "drive while strobe low", int'({de0, de1}), 0);
        @(posedge clk);
        if (wr0) m0[a[6:0]] = d;
        if (wr1) m1[a[6:0]] = d;
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            m0[i] = 8'h00;
            m1[i] = 8'h00;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R1: reset contents, read through the low half of u0
        for (int i = 0; i < 128; i++) cyc(13'h1000 | 13'(i), 8'h00, "R1");
        // R3/R4: fill u0 through its write half
        for (int i = 0; i < 128; i++) cyc(13'h1080 | 13'(i), pat(i, 1), "R3/R4");
        // R2: read back every u0 byte
        for (int i = 0; i < 128; i++) cyc(13'h1000 | 13'(i), 8'hFF, "R2");
        // R8: u1 has the halves swapped; fill through A7=0, read through A7=1
        for (int i = 0; i < 128; i++) cyc(13'h1000 | 13'(i), pat(i, 2), "R8");
        for (int i = 0; i < 128; i++) cyc(13'h1080 | 13'(i), 8'h00, "R8");
        for (int i = 0; i < 128; i++) cyc(13'h1080 | 13'(i), pat(i, 3), "R3");
        // R6: dummy accesses to ROM addresses above the RAM area
        for (int i = 1; i < 16; i++) begin
            for (int j = 0; j < 256; j += 29) cyc(13'h1000 | 13'(i << 8) | 13'(j), 8'hEE, "R6");
        end
        // R5: low address space, including offsets that would hit the RAM area
        for (int j = 0; j < 256; j += 7) cyc(13'(j), 8'hC3, "R5");
        for (int i = 0; i < 128; i++) cyc(13'h1000 | 13'(i), 8'h00, "R5");

        // R7: strobe held for three clocks, data changes before the strobe drops
        @(negedge clk);
        addr = 13'h1085; wdata = 8'h11; rom = 8'h85 ^ 8'h5A; strobe = 1'b1;
        @(negedge clk) wdata = 8'h33;
        @(negedge clk) wdata = 8'h44;
        @(negedge clk) begin strobe = 1'b0; wdata = 8'h22; end
        @(posedge clk);
        m0[5] = 8'h22;
        @(negedge clk) wdata = 8'h99;
        @(posedge clk);
        cyc(13'h1005, 8'h00, "R7");
        cyc(13'h1085, 8'h00, "R7");

        // R9: disable, try writes, verify ROM pass-through, then re-enable
        @(negedge clk) ram_on = 1'b0;
        @(posedge clk) en_m = 1'b0;
        for (int i = 0; i < 128; i += 5) cyc(13'h1080 | 13'(i), 8'hA5, "R9");
        for (int i = 0; i < 128; i += 5) cyc(13'h1000 | 13'(i), 8'hA5, "R9");
        @(negedge clk) ram_on = 1'b1;
        @(posedge clk) en_m = 1'b1;
        for (int i = 0; i < 128; i++) cyc(13'h1000 | 13'(i), 8'h00, "R9");
        for (int i = 0; i < 128; i++) cyc(13'h1080 | 13'(i), pat(i, 4), "R9");

        summary();
        $finish;
    end
endmodule